// File: doc/BRIEF.md
# Rising-Edge One-Shot Pulse Generator

This block watches a slowly changing trigger level and turns each low-to-high change into a single output pulse. The pulse is exactly one clock cycle wide. Once it has fired, the block stays unresponsive for as long as the trigger stays high. It arms again only after it has seen the trigger low at a clock edge. A trigger held high for any length of time therefore gives one pulse and no more.

The block is a three-state machine with one flip-flop per state:

- **Armed**: waiting for the trigger to go high.
- **Fire**: the pulse cycle.
- **Hold**: waiting for the trigger to return low.

Exactly one of the three flip-flops is set at any time. The output is taken directly from the Fire flip-flop. The 3-bit state is brought out for observation. The trigger is assumed to be already synchronous to the clock and to change much more slowly than the clock.

Top module: `oneshot_pulse`

## Requirements
- R1: While `rst` is high at a clock edge, the state after that edge is Armed (`state` = 3'b001) and `pulse` is 0, whatever the value of `trig`.
- R2: `state` is one-hot at all times outside reset. Bit 0 is Armed, bit 1 is Fire, bit 2 is Hold.
- R3: In Armed, if `trig` is high at a clock edge, the state after that edge is Fire (3'b010) and `pulse` is 1.
- R4: Fire always moves to Hold (3'b100) at the next edge, whatever `trig` is. This makes `pulse` exactly one cycle wide.
- R5: In Hold, while `trig` stays high, the state stays Hold and no further pulse appears.
- R6: In Hold, if `trig` is low at a clock edge, the state after that edge is Armed.
- R7: In Armed, if `trig` is low at a clock edge, the state stays Armed and `pulse` stays 0.
- R8: A trigger that is high for a single clock edge gives exactly one pulse and the sequence Armed, Fire, Hold, Armed. Trigger toggles that are spaced apart give one pulse per rising edge.
- R9: `pulse` is high exactly when the state is Fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Trigger level, synchronous to `clk` |
| pulse | output | 1 | One-cycle pulse on an accepted rising edge |
| state | output | 3 | One-hot state: bit 0 Armed, bit 1 Fire, bit 2 Hold |

## Verification
Every result comes from a register and depends only on the trigger level at one edge. A trigger first seen high at edge k makes `pulse` high after edge k and low again after edge k+1. Hold is left at the first edge that sees the trigger low. The bench changes `trig` only on falling edges and samples `state` and `pulse` on the falling edge after each rising edge. Each sample is compared with the state the requirements predict for that exact cycle, and pulses are counted over every cycle of a scenario.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    localparam int NUM_STATES = 3;

    localparam int IDX_ARMED = 0;
    localparam int IDX_FIRE  = 1;
    localparam int IDX_HOLD  = 2;

    typedef logic [NUM_STATES-1:0] onehot_t;

    localparam onehot_t ST_ARMED = onehot_t'(1) << IDX_ARMED;
    localparam onehot_t ST_FIRE  = onehot_t'(1) << IDX_FIRE;
    localparam onehot_t ST_HOLD  = onehot_t'(1) << IDX_HOLD;

    function automatic logic is_legal(onehot_t s);
        int n;
        n = 0;
        for (int i = 0; i < NUM_STATES; i++) begin
            n += int'(s[i]);
        end
        return (n == 1);
    endfunction

endpackage

// File: rtl/oneshot_next_state.sv
module oneshot_next_state
    import oneshot_pkg::*;
(
    input  onehot_t cur,
    input  logic    trig,
    output onehot_t nxt
);

    onehot_t eqn;

    always_comb begin
        eqn            = '0;
        eqn[IDX_ARMED] = (cur[IDX_ARMED] | cur[IDX_HOLD]) & ~trig;
        eqn[IDX_FIRE]  = cur[IDX_ARMED] & trig;
        eqn[IDX_HOLD]  = (cur[IDX_HOLD] & trig) | cur[IDX_FIRE];
        nxt            = is_legal(cur) ? eqn : ST_ARMED;
    end

endmodule

// File: rtl/oneshot_state_reg.sv
module oneshot_state_reg
    import oneshot_pkg::*;
#(
    parameter onehot_t RESET_CODE = ST_ARMED
)(
    input  logic    clk,
    input  logic    rst,
    input  onehot_t d,
    output onehot_t q
);

    for (genvar i = 0; i < NUM_STATES; i++) begin : g_ff
        always_ff @(posedge clk) begin
            if (rst) q[i] <= RESET_CODE[i];
            else     q[i] <= d[i];
        end
    end

endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
    import oneshot_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    output logic       pulse,
    output logic [2:0] state
);

    onehot_t cur_st;
    onehot_t nxt_st;

    oneshot_next_state u_next (
        .cur  (cur_st),
        .trig (trig),
        .nxt  (nxt_st)
    );

    oneshot_state_reg #(.RESET_CODE(ST_ARMED)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt_st),
        .q   (cur_st)
    );

    assign pulse = cur_st[IDX_FIRE];
    assign state = cur_st;

endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk (
    input logic       clk,
    input logic       rst,
    input logic       trig,
    input logic       pulse,
    input logic [2:0] state
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state == 3'b001 && !pulse));

    // R2
    onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    // R3
    arm_to_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b001 && trig) |=> (state == 3'b010 && pulse));

    // R4
    fire_to_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b010) |=> (state == 3'b100 && !pulse));

    // R5
    hold_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b100 && trig) |=> (state == 3'b100 && !pulse));

    // R6
    hold_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b100 && !trig) |=> (state == 3'b001));

    // R7
    armed_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b001 && !trig) |=> (state == 3'b001 && !pulse));

endmodule

bind oneshot_pulse oneshot_pulse_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .trig  (trig),
    .pulse (pulse),
    .state (state)
);

// File: tb/tb_oneshot_pulse.sv
module tb_oneshot_pulse;

    logic       clk = 1'b0;
    logic       rst;
    logic       trig;
    logic       pulse;
    logic [2:0] state;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses;

    always #5 clk = ~clk;

    oneshot_pulse dut (
        .clk   (clk),
        .rst   (rst),
        .trig  (trig),
        .pulse (pulse),
        .state (state)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one rising edge, then sample on the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check("R9 pulse==fire", int'(pulse), int'(state == 3'b010));
        check("R2 one-hot", $countones(state), 1);
        if (pulse) pulses++;
    endtask

    task automatic t_reset();
        rst  = 1'b1;
        trig = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1 state in reset", int'(state), 1);
            check("R1 pulse in reset", int'(pulse), 0);
        end
        trig = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_idle_low();
        trig = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            check("R7 armed stays", int'(state), 1);
            check("R7 no pulse", int'(pulse), 0);
        end
    endtask

    task automatic t_long_high();
        pulses = 0;
        trig = 1'b1;
        step();
        check("R3 fire state", int'(state), 2);
        check("R3 pulse high", int'(pulse), 1);
        step();
        check("R4 hold state", int'(state), 4);
        check("R4 pulse low", int'(pulse), 0);
        for (int i = 0; i < 20; i++) begin
            step();
            check("R5 hold while high", int'(state), 4);
        end
        check("R5 one pulse for long high", pulses, 1);
        trig = 1'b0;
        step();
        check("R6 rearm", int'(state), 1);
    endtask

    task automatic t_fire_ignores_trig();
        trig = 1'b1;
        step();
        check("R3 fire state", int'(state), 2);
        trig = 1'b0;
        step();
        check("R4 fire->hold with trig low", int'(state), 4);
        step();
        check("R6 rearm", int'(state), 1);
    endtask

    task automatic t_single();
        pulses = 0;
        trig = 1'b1;
        step();
        check("R8 fire", int'(state), 2);
        trig = 1'b0;
        step();
        check("R8 hold", int'(state), 4);
        step();
        check("R8 armed", int'(state), 1);
        step();
        check("R8 single-cycle count", pulses, 1);
    endtask

    task automatic t_toggles();
        pulses = 0;
        for (int k = 0; k < 5; k++) begin
            trig = 1'b1;
            for (int i = 0; i < 3; i++) step();
            trig = 1'b0;
            for (int i = 0; i < 3; i++) step();
        end
        check("R8 one pulse per rising edge", pulses, 5);
    endtask

    task automatic t_reset_mid();
        trig = 1'b1;
        step();
        check("R3 fire before reset", int'(state), 2);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset from fire", int'(state), 1);
        check("R1 no pulse in reset", int'(pulse), 0);
        trig = 1'b0;
        rst = 1'b0;
        step();
        check("R7 armed after reset", int'(state), 1);
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst  = 1'b1;
        trig = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_low();
        t_long_high();
        t_fire_ignores_trig();
        t_single();
        t_toggles();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule